// File: doc/BRIEF.md
# Eight-Channel DAC Register Bank

This block is the digital register file behind an eight-channel voltage DAC. A serial front end that sits outside the block hands it complete 16-bit words. The top four bits of each word choose a target and the low twelve bits carry data. The targets are the eight channel holding registers, a configuration word, a pair power/speed word and a preset value. There are also four pair addresses, which load a code into one channel and the complement of that code into its partner.

Each channel has a holding register and an output latch. The latch copies its holding register on every clock while the load strobe is low. A user can therefore stage new codes on all channels and then apply them together, or hold the strobe low to get immediate updates. While the preset input is low, every channel output shows the preset value instead of its latch. Both strobes are asynchronous and pass through synchronisers before use. Data may arrive in twos-complement form, which is converted to offset binary. A resolution parameter clears the data bits that a 10-bit or 8-bit converter would ignore.

Top module: `octal_dac_regbank`

## Requirements
- R1: A word with address 0..7 (bits 15:12) loads bits 11:0, after conversion, into the holding register of channel 0..7 only. Address 11 changes no register and no output.
- R2: Address 12+p (p = 0..3) loads channel 2p with the converted data and channel 2p+1 with its bitwise inverse, masked to the resolution.
- R3: Address 8 stores the configuration word: bit 0 selects twos-complement input (`twos_mode`), bits 2:1 drive `ref_sel`, bit 3 drives `chain_en` and bit 4 drives `full_pd`.
- R4: Address 9 stores the pair word: bits 7:4 drive `pair_pd[3:0]` and bits 3:0 drive `pair_fast[3:0]`. Index 0 is pair 0/1 and index 3 is pair 6/7.
- R5: While `load_n` is low, each output latch follows its holding register, so a write shows at the outputs within four clocks. While `load_n` is high, the latches keep their values.
- R6: Address 10 stores the preset value. While `preset_n` is low, all eight outputs show that value within four clocks. When `preset_n` returns high, the outputs show their latches again.
- R7: While `rst_n` is low, every register and latch is zero, so all outputs are zero.
- R8: When `twos_mode` is 1, bit 11 of channel and preset data is inverted before it is stored.
- R9: With parameter `RES_BITS` set to 10 or 8, the lowest 2 or 4 stored bits of channel and preset data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Commits `wr_word` on this clock |
| wr_word | input | 16 | Address in bits 15:12, data in bits 11:0 |
| load_n | input | 1 | Asynchronous active-low latch load strobe |
| preset_n | input | 1 | Asynchronous active-low preset override |
| chan_out | output | 96 | Channel i output code at bits i*12 +: 12 |
| pair_pd | output | 4 | Per-pair power-down flags |
| pair_fast | output | 4 | Per-pair fast settling flags |
| full_pd | output | 1 | Global power-down |
| chain_en | output | 1 | Daisy-chain output enable |
| ref_sel | output | 2 | Reference select (0/1 external, 2 internal low, 3 internal high) |
| twos_mode | output | 1 | Input coding is twos complement |

## Verification
The assertions check on every cycle the invariants that need no scenario. A pair write leaves its two channels as masked complements. A reserved write leaves all state unchanged. Latches hold while the strobe is inactive and follow the holding register while it is active. Stored codes never carry bits below the resolution, and all channels agree while preset is active. Configuration fields and the coding conversion are also checked against the previous write. Only the bench scenarios can show the end-to-end effect at the ports: the latency through the strobe synchronisers, staged updates that appear together, the return from preset, a reset in the middle of a run, and the three resolution variants side by side.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;
  localparam int DATA_W = 12;
  localparam int ADDR_W = 4;
  localparam int N_CH   = 8;
  localparam int N_PAIR = N_CH / 2;

  typedef enum logic [2:0] {
    K_CHAN   = 3'd0,
    K_CFG    = 3'd1,
    K_PAIRW  = 3'd2,
    K_PRESET = 3'd3,
    K_RSVD   = 3'd4,
    K_DUAL   = 3'd5
  } cmd_kind_e;

  function automatic cmd_kind_e kind_of(input logic [ADDR_W-1:0] a);
    if (a < 4'd8)        return K_CHAN;
    else if (a == 4'd8)  return K_CFG;
    else if (a == 4'd9)  return K_PAIRW;
    else if (a == 4'd10) return K_PRESET;
    else if (a == 4'd11) return K_RSVD;
    else                 return K_DUAL;
  endfunction

  // bits kept for a given resolution
  function automatic logic [DATA_W-1:0] keep_mask(input int res);
    logic [DATA_W-1:0] m;
    m = '1;
    return m << (DATA_W - res);
  endfunction

  // coding conversion then resolution mask
  function automatic logic [DATA_W-1:0] fmt_code(input logic [DATA_W-1:0] d,
                                                 input logic twos,
                                                 input logic [DATA_W-1:0] m);
    logic [DATA_W-1:0] t;
    t = d;
    if (twos) t[DATA_W-1] = ~t[DATA_W-1];
    return t & m;
  endfunction
endpackage

// File: rtl/dacbank_sync.sv
module dacbank_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-2:0], async_in};
  end

  assign sync_out = sh[STAGES-1];
endmodule

// File: rtl/dacbank_decode.sv
module dacbank_decode
  import dacbank_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic                          wr_valid,
  input  logic [ADDR_W+DATA_W-1:0]      wr_word,
  input  logic                          twos,
  output logic [N_CH-1:0]               ch_we,
  output logic [N_CH-1:0][DATA_W-1:0]   ch_wdata,
  output logic                          cfg_we,
  output logic                          pairw_we,
  output logic                          preset_we,
  output logic                          rsvd_hit,
  output logic [DATA_W-1:0]             conv_data
);
  localparam logic [DATA_W-1:0] KEEP = keep_mask(RES_BITS);

  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] data;
  cmd_kind_e         kind;

  assign addr      = wr_word[ADDR_W+DATA_W-1:DATA_W];
  assign data      = wr_word[DATA_W-1:0];
  assign kind      = kind_of(addr);
  assign conv_data = fmt_code(data, twos, KEEP);

  assign cfg_we    = wr_valid && (kind == K_CFG);
  assign pairw_we  = wr_valid && (kind == K_PAIRW);
  assign preset_we = wr_valid && (kind == K_PRESET);
  assign rsvd_hit  = wr_valid && (kind == K_RSVD);

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] SELF = ADDR_W'(i);
    localparam logic [ADDR_W-1:0] DUAL = ADDR_W'(12 + i / 2);
    logic single_hit, dual_hit;
    assign single_hit = (kind == K_CHAN) && (addr == SELF);
    assign dual_hit   = (kind == K_DUAL) && (addr == DUAL);
    assign ch_we[i]   = wr_valid && (single_hit || dual_hit);
    if (i % 2 == 1) begin : g_odd
      assign ch_wdata[i] = dual_hit ? (~conv_data & KEEP) : conv_data;
    end else begin : g_even
      assign ch_wdata[i] = conv_data;
    end
  end
endmodule

// File: rtl/dacbank_chan.sv
module dacbank_chan
  import dacbank_pkg::*;
#(
  parameter logic [DATA_W-1:0] KEEP = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ld_en,
  output logic [DATA_W-1:0] hold_q,
  output logic [DATA_W-1:0] latch_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      latch_q <= '0;
    end else begin
      if (we)    hold_q  <= wdata;
      if (ld_en) latch_q <= hold_q;
    end
  end

  a_r5_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_en |=> $stable(latch_q));
  a_r5_latch_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (latch_q == $past(hold_q)));
  a_r9_low_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q & ~KEEP) == '0);
endmodule

// File: rtl/octal_dac_regbank.sv
module octal_dac_regbank
  import dacbank_pkg::*;
#(
  parameter int RES_BITS    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_valid,
  input  logic [15:0]            wr_word,
  input  logic                   load_n,
  input  logic                   preset_n,
  output logic [N_CH*DATA_W-1:0] chan_out,
  output logic [N_PAIR-1:0]      pair_pd,
  output logic [N_PAIR-1:0]      pair_fast,
  output logic                   full_pd,
  output logic                   chain_en,
  output logic [1:0]             ref_sel,
  output logic                   twos_mode
);
  localparam logic [DATA_W-1:0] KEEP = keep_mask(RES_BITS);

  logic                        ld_n_s, pre_n_s, ld_en, pre_act;
  logic [N_CH-1:0]             ch_we;
  logic [N_CH-1:0][DATA_W-1:0] ch_wdata, hold_v, latch_v;
  logic                        cfg_we, pairw_we, preset_we, rsvd_hit;
  logic [DATA_W-1:0]           conv_data, preset_q;
  logic [4:0]                  cfg_q;
  logic [7:0]                  pairw_q;

  dacbank_sync #(.STAGES(SYNC_STAGES)) u_ld_sync (
    .clk(clk), .rst_n(rst_n), .async_in(load_n), .sync_out(ld_n_s));
  dacbank_sync #(.STAGES(SYNC_STAGES)) u_pre_sync (
    .clk(clk), .rst_n(rst_n), .async_in(preset_n), .sync_out(pre_n_s));

  assign ld_en   = ~ld_n_s;
  assign pre_act = ~pre_n_s;

  dacbank_decode #(.RES_BITS(RES_BITS)) u_dec (
    .wr_valid(wr_valid), .wr_word(wr_word), .twos(cfg_q[0]),
    .ch_we(ch_we), .ch_wdata(ch_wdata), .cfg_we(cfg_we),
    .pairw_we(pairw_we), .preset_we(preset_we), .rsvd_hit(rsvd_hit),
    .conv_data(conv_data));

  for (genvar i = 0; i < N_CH; i++) begin : g_chan
    dacbank_chan #(.KEEP(KEEP)) u_ch (
      .clk(clk), .rst_n(rst_n), .we(ch_we[i]), .wdata(ch_wdata[i]),
      .ld_en(ld_en), .hold_q(hold_v[i]), .latch_q(latch_v[i]));
    assign chan_out[i*DATA_W +: DATA_W] = pre_act ? preset_q : latch_v[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      pairw_q  <= '0;
      preset_q <= '0;
    end else begin
      if (cfg_we)    cfg_q    <= wr_word[4:0];
      if (pairw_we)  pairw_q  <= wr_word[7:0];
      if (preset_we) preset_q <= conv_data;
    end
  end

  assign twos_mode = cfg_q[0];
  assign ref_sel   = cfg_q[2:1];
  assign chain_en  = cfg_q[3];
  assign full_pd   = cfg_q[4];
  assign pair_pd   = pairw_q[7:4];
  assign pair_fast = pairw_q[3:0];

  a_r1_reserved_inert: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd_hit |=> ($stable(hold_v) && $stable(cfg_q) && $stable(pairw_q)
                  && $stable(preset_q)));
  a_r3_cfg_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_word[15:12] == 4'd8) |=>
      (ref_sel == $past(wr_word[2:1]) && full_pd == $past(wr_word[4])));
  a_r4_pair_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_word[15:12] == 4'd9) |=>
      ({pair_pd, pair_fast} == $past(wr_word[7:0])));

  for (genvar p = 0; p < N_PAIR; p++) begin : g_pair_chk
    a_r2_pair_complement: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_word[15:12] == 4'(12 + p)) |=>
        ((hold_v[2*p] ^ hold_v[2*p+1]) == KEEP));
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_ch_chk
    a_r6_preset_uniform: assert property (@(posedge clk) disable iff (!rst_n)
      pre_act |-> (chan_out[i*DATA_W +: DATA_W] == chan_out[DATA_W-1:0]));
    a_r8_msb_flip: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_word[15:12] == 4'(i)) |=>
        (hold_v[i][DATA_W-1] == ($past(wr_word[11]) ^ $past(twos_mode))));
  end
endmodule

// File: tb/sim_octal_dac_regbank.sv
module sim_octal_dac_regbank;
  localparam int CLK_P = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_valid = 0;
  logic [15:0] wr_word = '0;
  logic        load_n = 0;
  logic        preset_n = 1;
  logic [95:0] out0, out1, out2;
  logic [3:0]  ppd0, pfast0, ppd1, pfast1, ppd2, pfast2;
  logic        fpd0, chn0, tw0, fpd1, chn1, tw1, fpd2, chn2, tw2;
  logic [1:0]  ref0, ref1, ref2;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  octal_dac_regbank u0 (.clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_word(wr_word),
    .load_n(load_n), .preset_n(preset_n), .chan_out(out0), .pair_pd(ppd0),
    .pair_fast(pfast0), .full_pd(fpd0), .chain_en(chn0), .ref_sel(ref0), .twos_mode(tw0));
  octal_dac_regbank #(.RES_BITS(10)) u1 (.clk(clk), .rst_n(rst_n), .wr_valid(wr_valid),
    .wr_word(wr_word), .load_n(load_n), .preset_n(preset_n), .chan_out(out1),
    .pair_pd(ppd1), .pair_fast(pfast1), .full_pd(fpd1), .chain_en(chn1), .ref_sel(ref1),
    .twos_mode(tw1));
  octal_dac_regbank #(.RES_BITS(8)) u2 (.clk(clk), .rst_n(rst_n), .wr_valid(wr_valid),
    .wr_word(wr_word), .load_n(load_n), .preset_n(preset_n), .chan_out(out2),
    .pair_pd(ppd2), .pair_fast(pfast2), .full_pd(fpd2), .chain_en(chn2), .ref_sel(ref2),
    .twos_mode(tw2));

  // {word, chan a, expected a, chan b, expected b}; load_n low, binary coding
  localparam logic [45:0] VEC [8] = '{
    {16'h0123, 3'd0, 12'h123, 3'd1, 12'h000},
    {16'h7ABC, 3'd7, 12'hABC, 3'd0, 12'h123},
    {16'hC5A5, 3'd0, 12'h5A5, 3'd1, 12'hA5A},
    {16'hF00F, 3'd6, 12'h00F, 3'd7, 12'hFF0},
    {16'hD800, 3'd2, 12'h800, 3'd3, 12'h7FF},
    {16'hB777, 3'd0, 12'h5A5, 3'd7, 12'hFF0},
    {16'hE001, 3'd4, 12'h001, 3'd5, 12'hFFE},
    {16'h5321, 3'd5, 12'h321, 3'd4, 12'h001}
  };

  function automatic logic [11:0] ch(input logic [95:0] v, input int i);
    return v[i*12 +: 12];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] w);
    @(negedge clk); wr_valid = 1; wr_word = w;
    @(negedge clk); wr_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    chk("R7 reset outputs", {20'h0, ch(out0, 0)}, 0);
    rst_n = 1;
    idle(2);
    chk("R7 reset out7", {20'h0, ch(out0, 7)}, 0);
    chk("R7 reset cfg", {25'h0, fpd0, chn0, ref0, tw0, ppd0 != 0}, 0);

    for (int k = 0; k < 8; k++) begin
      wr(VEC[k][45:30]);
      idle(2);
      chk($sformatf("R1/R2 vec%0d a", k), {20'h0, ch(out0, int'(VEC[k][29:27]))}, {20'h0, VEC[k][26:15]});
      chk($sformatf("R1/R2 vec%0d b", k), {20'h0, ch(out0, int'(VEC[k][14:12]))}, {20'h0, VEC[k][11:0]});
    end

    // R3 configuration fields
    wr(16'h801F);
    idle(1);
    chk("R3 full_pd", {31'h0, fpd0}, 1);
    chk("R3 chain_en", {31'h0, chn0}, 1);
    chk("R3 ref_sel", {30'h0, ref0}, 3);
    chk("R3 twos_mode", {31'h0, tw0}, 1);
    wr(16'h8004);
    idle(1);
    chk("R3 ref_sel low", {28'h0, fpd0, chn0, ref0}, {28'h0, 4'b0010});
    wr(16'h8001);
    // R8 twos-complement conversion
    wr(16'h1000); idle(2);
    chk("R8 zero to mid", {20'h0, ch(out0, 1)}, 32'h800);
    wr(16'h27FF); idle(2);
    chk("R8 max positive", {20'h0, ch(out0, 2)}, 32'hFFF);
    wr(16'hC800); idle(2);
    chk("R8 pair first", {20'h0, ch(out0, 0)}, 32'h000);
    chk("R8 pair second", {20'h0, ch(out0, 1)}, 32'hFFF);
    wr(16'h8000); idle(1);
    chk("R3 cleared", {27'h0, fpd0, chn0, ref0, tw0}, 0);

    // R4 pair word
    wr(16'h90A5); idle(1);
    chk("R4 pair_pd", {28'h0, ppd0}, 32'hA);
    chk("R4 pair_fast", {28'h0, pfast0}, 32'h5);

    // R5 staged load
    load_n = 1; idle(4);
    wr(16'h0ABC); wr(16'h7123); idle(4);
    chk("R5 held ch0", {20'h0, ch(out0, 0)}, 32'h000);
    chk("R5 held ch7", {20'h0, ch(out0, 7)}, 32'hFF0);
    load_n = 0; idle(4);
    chk("R5 applied ch0", {20'h0, ch(out0, 0)}, 32'hABC);
    chk("R5 applied ch7", {20'h0, ch(out0, 7)}, 32'h123);

    // R6 preset override
    wr(16'hA3C3); idle(2);
    chk("R6 not yet", {20'h0, ch(out0, 3)}, 32'h7FF);
    preset_n = 0; idle(4);
    for (int i = 0; i < 8; i++) chk($sformatf("R6 preset ch%0d", i), {20'h0, ch(out0, i)}, 32'h3C3);
    preset_n = 1; idle(4);
    chk("R6 release", {20'h0, ch(out0, 0)}, 32'hABC);

    // R9 resolution variants
    wr(16'h0ABF); idle(2);
    chk("R9 12-bit", {20'h0, ch(out0, 0)}, 32'hABF);
    chk("R9 10-bit", {20'h0, ch(out1, 0)}, 32'hABC);
    chk("R9 8-bit", {20'h0, ch(out2, 0)}, 32'hAB0);
    wr(16'hCAB5); idle(2);
    chk("R9 R2 pair 12-bit", {20'h0, ch(out0, 1)}, 32'h54A);
    chk("R9 R2 pair 10-bit", {20'h0, ch(out1, 1)}, 32'h548);
    chk("R9 R2 pair 8-bit", {20'h0, ch(out2, 1)}, 32'h540);

    // R7 reset mid-run
    @(negedge clk); rst_n = 0;
    idle(1);
    chk("R7 mid reset ch0", {20'h0, ch(out0, 0)}, 0);
    chk("R7 mid reset pair", {28'h0, ppd0}, 0);
    rst_n = 1; idle(2);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule